// File: doc/BRIEF.md
# Configuration Port Bridge

This block turns the classic two-port indirect configuration mechanism into register accesses on a set of device functions. A host on a 32-bit port bus first writes a packed configuration address to the address port, then reads or writes the data port; the bridge decodes bus, device, function and dword index from the latched address and routes the data access to the selected register. Absent targets, and all accesses made while the enable bit is clear, read back as all ones, so a host that scans for devices sees a vendor ID of 0xFFFF where nothing is fitted.

A small built-in model stands behind the data port. It holds `NUM_FUNCS` functions of one device at a fixed bus and device number. Each function has a 64-dword header with fixed identity registers, a writable command field and a parameterised set of base address registers. The model lets a bench exercise the whole path from port access to header register.

Every port access finishes with a single-cycle ready pulse on the clock edge after the strobe. Read data is valid in that same cycle.

Top module: `cfgPortBridge`

## Requirements
- R1: After reset the latched address reads 0, `portReady` is low, every command field is 0 and every base address register holds only its type bits.
- R2: A write to port `ADDR_PORT` (default 0x0CF8) loads the address register with bits 1:0 cleared; a read of that port returns the stored value.
- R3: Address layout: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index. A read of port `DATA_PORT` (default 0x0CFC) returns the selected dword of the selected function.
- R4: When the bus differs from `BUS_NUM`, the device differs from `DEV_NUM`, or the function is not below `NUM_FUNCS`, a data read returns 0xFFFFFFFF and a data write changes nothing.
- R5: With address bit 31 clear, a data read returns 0xFFFFFFFF and a data write is discarded.
- R6: Dword 0 reads {`DEVICE_ID_BASE`+f, `VENDOR_ID`}, dword 2 reads {`CLASS_CODE`, f as revision}, and dword 3 carries the header type in bits 23:16 with bit 23 set when `NUM_FUNCS` > 1 and every other bit of dword 3 zero. Writes to dwords 0, 2 and 3 have no effect.
- R7: Dword 1 bits 15:0 are a writable command field and bits 31:16 read as zero.
- R8: Base address register b sits at dword 4+b for b below `NUM_BARS`. An even b is a memory range: bits 3:0 read 0 and bits 31:`MEM_BAR_BITS` are writable. An odd b is an I/O range: bit 0 reads 1, bit 1 reads 0 and bits 31:`IO_BAR_BITS` are writable. Writing all ones therefore reads back the size mask.
- R9: Dwords from 4+`NUM_BARS` up to 63 read zero and ignore writes.
- R10: `portReady` is high for exactly the one cycle after each cycle with `portRd` or `portWr` high, and low otherwise; `portRdData` is valid while it is high.
- R11: An access to any other port address still produces the ready pulse and read data 0. It changes neither the latched address nor any header register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 16 | Port address of the access |
| portWrData | input | 32 | Write data |
| portRd | input | 1 | Read strobe, one cycle per access |
| portWr | input | 1 | Write strobe, one cycle per access |
| portRdData | output | 32 | Read data, valid with portReady |
| portReady | output | 1 | Access completion pulse |

## Verification
The assertions take as given that the host raises `portRd` and `portWr` for one cycle per access and never raises both together, and that `portAddr` and `portWrData` are stable while a strobe is high. The bench drives each access as a single-cycle strobe set up on the falling edge, with one idle cycle between accesses, and it never overlaps a read with a write. Under that discipline the ready-pulse properties and the strobe-exclusivity property describe the host's contract. A sweep of all 256 device and function pairs, together with full 64-dword header scans, exercises the decode and masking properties.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic addrWr;
    logic addrRd;
    logic dataWr;
    logic dataRd;
    logic anyAccess;
  } cfgStrobe_t;

  // Field positions of the latched configuration address.
  localparam int ENABLE_POS = 31;
  localparam int BUS_LSB    = 16;
  localparam int DEV_LSB    = 11;
  localparam int FUNC_LSB   = 8;
  localparam int REG_LSB    = 2;

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

endpackage

// File: rtl/cfgBridgeCtrl.sv
module cfgBridgeCtrl
  import cfg_bridge_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] portAddr,
  input  logic        portRd,
  input  logic        portWr,
  output cfgStrobe_t  strb,
  output logic        portReady
);

  logic isAddrPort;
  logic isDataPort;
  logic rdOnly;
  logic readyQ;

  assign isAddrPort = (portAddr == ADDR_PORT);
  assign isDataPort = (portAddr == DATA_PORT);
  // A write wins when both strobes are raised together.
  assign rdOnly = portRd & ~portWr;

  always_comb begin
    strb.addrWr    = portWr & isAddrPort;
    strb.addrRd    = rdOnly & isAddrPort;
    strb.dataWr    = portWr & isDataPort;
    strb.dataRd    = rdOnly & isDataPort;
    strb.anyAccess = portRd | portWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= portRd | portWr;
  end

  assign portReady = readyQ;

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (portRd || portWr) |=> portReady);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(portRd || portWr) |=> !portReady);

endmodule

// File: rtl/cfgFuncModel.sv
module cfgFuncModel #(
  parameter int          FUNC_IDX       = 0,
  parameter int          NUM_FUNCS      = 2,
  parameter logic [15:0] VENDOR_ID      = 16'h5A17,
  parameter logic [15:0] DEVICE_ID_BASE = 16'h0C40,
  parameter logic [23:0] CLASS_CODE     = 24'h028000,
  parameter int          NUM_BARS       = 2,
  parameter int          MEM_BAR_BITS   = 12,
  parameter int          IO_BAR_BITS    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [5:0]  regIdx,
  input  logic [31:0] wrData,
  output logic [31:0] rdData
);

  localparam logic [7:0]  HDR_TYPE = (NUM_FUNCS > 1) ? 8'h80 : 8'h00;
  localparam logic [15:0] DEV_ID   = 16'(DEVICE_ID_BASE + 16'(FUNC_IDX));
  localparam logic [7:0]  REV_ID   = 8'(FUNC_IDX);

  logic [15:0] cmdQ;
  logic [31:0] barQ [NUM_BARS];

  always_ff @(posedge clk) begin
    if (!rstN)                              cmdQ <= 16'h0;
    else if (wrEn && regIdx == 6'd1)        cmdQ <= wrData[15:0];
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    localparam bit          IS_IO     = (b % 2) == 1;
    localparam int          SIZE_BITS = IS_IO ? IO_BAR_BITS : MEM_BAR_BITS;
    localparam logic [31:0] RW_MASK   = ~((32'h1 << SIZE_BITS) - 32'h1);
    localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : 32'h0;

    always_ff @(posedge clk) begin
      if (!rstN)                                   barQ[b] <= TYPE_BITS;
      else if (wrEn && regIdx == 6'(4 + b))        barQ[b] <= (wrData & RW_MASK) | TYPE_BITS;
    end

    assert_bar_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      !wrEn |=> $stable(barQ[b]));
    assert_bar_type_R8: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |=> (barQ[b][0] == IS_IO));
  end

  always_comb begin
    rdData = 32'h0;
    case (regIdx)
      6'd0: rdData = {DEV_ID, VENDOR_ID};
      6'd1: rdData = {16'h0, cmdQ};
      6'd2: rdData = {CLASS_CODE, REV_ID};
      6'd3: rdData = {8'h0, HDR_TYPE, 16'h0};
      default: begin
        for (int b = 0; b < NUM_BARS; b++) begin
          if (regIdx == 6'(4 + b)) rdData = barQ[b];
        end
      end
    endcase
  end

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cmdQ));

endmodule

// File: rtl/cfgBridgeDatapath.sv
module cfgBridgeDatapath
  import cfg_bridge_pkg::*;
#(
  parameter int          BUS_NUM        = 0,
  parameter int          DEV_NUM        = 5,
  parameter int          NUM_FUNCS      = 2,
  parameter logic [15:0] VENDOR_ID      = 16'h5A17,
  parameter logic [15:0] DEVICE_ID_BASE = 16'h0C40,
  parameter logic [23:0] CLASS_CODE     = 24'h028000,
  parameter int          NUM_BARS       = 2,
  parameter int          MEM_BAR_BITS   = 12,
  parameter int          IO_BAR_BITS    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strb,
  input  logic [31:0] portWrData,
  output logic [31:0] portRdData
);

  localparam logic [7:0] BUS_SEL = 8'(BUS_NUM);
  localparam logic [4:0] DEV_SEL = 5'(DEV_NUM);

  logic [31:0] cfgAddrQ;
  logic [31:0] rdDataQ;
  logic [31:0] rdNext;
  logic [7:0]  busSel;
  logic [4:0]  devSel;
  logic [2:0]  fnSel;
  logic [5:0]  regSel;
  logic        enabled;
  logic        hit;
  logic [31:0] funcRd [NUM_FUNCS];
  logic [31:0] selRd;

  assign enabled = cfgAddrQ[ENABLE_POS];
  assign busSel  = cfgAddrQ[BUS_LSB +: 8];
  assign devSel  = cfgAddrQ[DEV_LSB +: 5];
  assign fnSel   = cfgAddrQ[FUNC_LSB +: 3];
  assign regSel  = cfgAddrQ[REG_LSB +: 6];
  assign hit     = (busSel == BUS_SEL) && (devSel == DEV_SEL) && (32'(fnSel) < NUM_FUNCS);

  always_ff @(posedge clk) begin
    if (!rstN)            cfgAddrQ <= 32'h0;
    else if (strb.addrWr) cfgAddrQ <= {portWrData[31:2], 2'b00};
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
    logic fnWrEn;
    assign fnWrEn = strb.dataWr & enabled & hit & (32'(fnSel) == f);

    cfgFuncModel #(
      .FUNC_IDX      (f),
      .NUM_FUNCS     (NUM_FUNCS),
      .VENDOR_ID     (VENDOR_ID),
      .DEVICE_ID_BASE(DEVICE_ID_BASE),
      .CLASS_CODE    (CLASS_CODE),
      .NUM_BARS      (NUM_BARS),
      .MEM_BAR_BITS  (MEM_BAR_BITS),
      .IO_BAR_BITS   (IO_BAR_BITS)
    ) func_i (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (fnWrEn),
      .regIdx(regSel),
      .wrData(portWrData),
      .rdData(funcRd[f])
    );
  end

  always_comb begin
    selRd = ALL_ONES;
    for (int f = 0; f < NUM_FUNCS; f++) begin
      if (32'(fnSel) == f) selRd = funcRd[f];
    end
  end

  always_comb begin
    rdNext = 32'h0;
    if (strb.addrRd)      rdNext = cfgAddrQ;
    else if (strb.dataRd) rdNext = (enabled && hit) ? selRd : ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdDataQ <= 32'h0;
    else       rdDataQ <= rdNext;
  end

  assign portRdData = rdDataQ;

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.addrWr, strb.addrRd, strb.dataWr, strb.dataRd}));
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrRd |=> (portRdData[1:0] == 2'b00));
  assert_disabled_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && !enabled) |=> (portRdData == ALL_ONES));
  assert_absent_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && !hit) |=> (portRdData == ALL_ONES));
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.anyAccess |=> (portRdData == 32'h0));

endmodule

// File: rtl/cfgPortBridge.sv
module cfgPortBridge
  import cfg_bridge_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT      = 16'h0CF8,
  parameter logic [15:0] DATA_PORT      = 16'h0CFC,
  parameter int          BUS_NUM        = 0,
  parameter int          DEV_NUM        = 5,
  parameter int          NUM_FUNCS      = 2,
  parameter logic [15:0] VENDOR_ID      = 16'h5A17,
  parameter logic [15:0] DEVICE_ID_BASE = 16'h0C40,
  parameter logic [23:0] CLASS_CODE     = 24'h028000,
  parameter int          NUM_BARS       = 2,
  parameter int          MEM_BAR_BITS   = 12,
  parameter int          IO_BAR_BITS    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] portAddr,
  input  logic [31:0] portWrData,
  input  logic        portRd,
  input  logic        portWr,
  output logic [31:0] portRdData,
  output logic        portReady
);

  cfgStrobe_t strb;

  cfgBridgeCtrl #(
    .ADDR_PORT(ADDR_PORT),
    .DATA_PORT(DATA_PORT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .portAddr (portAddr),
    .portRd   (portRd),
    .portWr   (portWr),
    .strb     (strb),
    .portReady(portReady)
  );

  cfgBridgeDatapath #(
    .BUS_NUM       (BUS_NUM),
    .DEV_NUM       (DEV_NUM),
    .NUM_FUNCS     (NUM_FUNCS),
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID_BASE(DEVICE_ID_BASE),
    .CLASS_CODE    (CLASS_CODE),
    .NUM_BARS      (NUM_BARS),
    .MEM_BAR_BITS  (MEM_BAR_BITS),
    .IO_BAR_BITS   (IO_BAR_BITS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .portWrData(portWrData),
    .portRdData(portRdData)
  );

endmodule

// File: tb/cfgPortBridge_tb.sv
`timescale 1ns/1ps
module cfgPortBridge_tb_top;

  localparam logic [15:0] AP    = 16'h0CF8;
  localparam logic [15:0] DP    = 16'h0CFC;
  localparam int          DEVN  = 5;
  localparam int          NFN   = 2;
  localparam logic [15:0] VEN   = 16'h5A17;
  localparam logic [15:0] DIDB  = 16'h0C40;
  localparam logic [23:0] CLS   = 24'h028000;
  localparam int          NBAR  = 2;
  localparam int          MEMB  = 12;
  localparam int          IOB   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] portAddr = 16'h0;
  logic [31:0] portWrData = 32'h0;
  logic        portRd = 1'b0;
  logic        portWr = 1'b0;
  logic [31:0] portRdData;
  logic        portReady;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] expCmd [NFN];
  logic [31:0] expBar [NFN][NBAR];

  always #5 clk = ~clk;

  cfgPortBridge dut_i (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWrData(portWrData),
    .portRd(portRd), .portWr(portWr), .portRdData(portRdData), .portReady(portReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: strobe for a single cycle, sample at the next falling edge.
  task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    portAddr = a; portWrData = d; portWr = wr; portRd = !wr;
    @(negedge clk);
    portWr = 1'b0; portRd = 1'b0;
    check("R10 ready pulse", {31'h0, portReady}, 32'h1);
    q = portRdData;
    @(negedge clk);
    if (portReady !== 1'b0) check("R10 ready single cycle", {31'h0, portReady}, 32'h0);
  endtask

  function automatic logic [31:0] mkAddr(bit en, int bus, int dev, int fn, int rg);
    return {en, 7'h0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
  endfunction

  function automatic logic [31:0] expDword(int f, int rg);
    if (rg == 0) return {16'(DIDB + 16'(f)), VEN};
    if (rg == 1) return {16'h0, expCmd[f]};
    if (rg == 2) return {CLS, 8'(f)};
    if (rg == 3) return {8'h0, (NFN > 1) ? 8'h80 : 8'h00, 16'h0};
    if (rg >= 4 && rg < 4 + NBAR) return expBar[f][rg-4];
    return 32'h0;
  endfunction

  function automatic logic [31:0] barMask(int b);
    int sz = (b % 2 == 1) ? IOB : MEMB;
    return ~((32'h1 << sz) - 32'h1);
  endfunction

  task automatic cfgRead(input logic [31:0] a, output logic [31:0] q);
    logic [31:0] dummy;
    access(1'b1, AP, a, dummy);
    access(1'b0, DP, 32'h0, q);
  endtask

  task automatic cfgWrite(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, AP, a, dummy);
    access(1'b1, DP, d, dummy);
  endtask

  task automatic scanAll(input string req);
    logic [31:0] q;
    for (int f = 0; f < NFN; f++)
      for (int rg = 0; rg < 64; rg++) begin
        cfgRead(mkAddr(1, 0, DEVN, f, rg), q);
        check(req, q, expDword(f, rg));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    for (int f = 0; f < NFN; f++) begin
      expCmd[f] = 16'h0;
      for (int b = 0; b < NBAR; b++) expBar[f][b] = (b % 2 == 1) ? 32'h1 : 32'h0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready low after reset", {31'h0, portReady}, 32'h0);
    access(1'b0, AP, 32'h0, q);
    check("R1 address register reset", q, 32'h0);
    // Reset header contents, R1/R6/R8/R9
    scanAll("R1 reset header scan");

    // R2: latch with low bits cleared
    access(1'b1, AP, 32'hDEAD_BEEF, q);
    access(1'b0, AP, 32'h0, q);
    check("R2 address latch aligned", q, 32'hDEAD_BEEC);

    // R3/R4: sweep every device and function on the home bus
    for (int d = 0; d < 32; d++)
      for (int f = 0; f < 8; f++) begin
        cfgRead(mkAddr(1, 0, d, f, 0), q);
        check("R3 R4 device sweep", q,
              (d == DEVN && f < NFN) ? {16'(DIDB + 16'(f)), VEN} : 32'hFFFF_FFFF);
      end
    cfgRead(mkAddr(1, 1, DEVN, 0, 0), q);
    check("R4 other bus", q, 32'hFFFF_FFFF);

    // R5: disabled read and write
    cfgRead(mkAddr(0, 0, DEVN, 0, 0), q);
    check("R5 disabled read", q, 32'hFFFF_FFFF);
    cfgWrite(mkAddr(0, 0, DEVN, 0, 1), 32'h0000_7777);
    cfgRead(mkAddr(1, 0, DEVN, 0, 1), q);
    check("R5 disabled write discarded", q, 32'h0);

    // R7: command field
    cfgWrite(mkAddr(1, 0, DEVN, 0, 1), 32'hABCD_1234); expCmd[0] = 16'h1234;
    cfgWrite(mkAddr(1, 0, DEVN, 1, 1), 32'hFFFF_0F0F); expCmd[1] = 16'h0F0F;
    cfgRead(mkAddr(1, 0, DEVN, 0, 1), q);
    check("R7 command write", q, 32'h0000_1234);

    // R4: write to absent function and device changes nothing
    cfgWrite(mkAddr(1, 0, DEVN, 2, 1), 32'h0000_5555);
    cfgWrite(mkAddr(1, 0, DEVN + 1, 0, 4), 32'hFFFF_FFFF);

    // R6/R9: writes to read-only dwords
    for (int f = 0; f < NFN; f++) begin
      cfgWrite(mkAddr(1, 0, DEVN, f, 0), 32'h1111_2222);
      cfgWrite(mkAddr(1, 0, DEVN, f, 2), 32'h3333_4444);
      cfgWrite(mkAddr(1, 0, DEVN, f, 3), 32'hFFFF_FFFF);
      cfgWrite(mkAddr(1, 0, DEVN, f, 4 + NBAR), 32'hFFFF_FFFF);
      cfgWrite(mkAddr(1, 0, DEVN, f, 63), 32'hFFFF_FFFF);
    end

    // R8: size probe with all ones, then a real address
    for (int b = 0; b < NBAR; b++) begin
      cfgWrite(mkAddr(1, 0, DEVN, 0, 4 + b), 32'hFFFF_FFFF);
      expBar[0][b] = barMask(b) | ((b % 2 == 1) ? 32'h1 : 32'h0);
      cfgRead(mkAddr(1, 0, DEVN, 0, 4 + b), q);
      check("R8 size probe", q, expBar[0][b]);
      cfgWrite(mkAddr(1, 0, DEVN, 1, 4 + b), 32'h1234_5677);
      expBar[1][b] = (32'h1234_5677 & barMask(b)) | ((b % 2 == 1) ? 32'h1 : 32'h0);
    end

    // R11: other port addresses
    access(1'b1, AP, mkAddr(1, 0, DEVN, 1, 1), q);
    access(1'b1, 16'h0CF9, 32'h0, q);
    access(1'b1, 16'h0080, 32'hFFFF_FFFF, q);
    access(1'b1, 16'h0CFD, 32'h0000_9999, q);
    access(1'b0, 16'h0064, 32'h0, q);
    check("R11 other port read zero", q, 32'h0);
    access(1'b0, AP, 32'h0, q);
    check("R11 address unchanged", q, mkAddr(1, 0, DEVN, 1, 1));
    access(1'b0, DP, 32'h0, q);
    check("R11 header unchanged", q, {16'h0, expCmd[1]});

    scanAll("R6 R7 R8 R9 final header scan");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule